// File: doc/BRIEF.md
# Valid-Bit Command Ring Consumer

This block drains a shared command ring that software producers fill. The ring holds a power-of-two number of fixed-size slots, 32 bytes each by default. A producer writes every field of a slot and sets the slot's valid bit as its last step. The block reads the slot at its own consumer index and treats the slot as fresh work only when the valid bit equals the polarity it currently expects. The expected polarity starts at 1 and inverts each time the index wraps back to slot 0, so producer and consumer pointers never have to be compared.

A fresh slot is captured into a holding register and offered to a downstream engine over a ready/valid handshake. The consumer index advances only when the engine takes the command. The index is a port, so a producer that prefers pointer-based flow control can read it. Results from the engine are written into a response ring. Each response slot carries a valid bit that the block sets from its own wrap-toggling polarity.

Top module: `vbit_cmd_consumer`

## Requirements
- R1: After reset, cmd_idx and rsp_idx are 0, eng_valid and rsp_we are 0, and the expected command polarity is 1.
- R2: The valid bit is slot bit 7 (the top bit of byte 0). A slot at cmd_idx whose bit 7 differs from the expected polarity is ignored: eng_valid stays 0 and cmd_idx does not move.
- R3: When the slot at cmd_idx has a matching valid bit and no command is held, eng_valid is 1 after the next clock edge, and eng_cmd equals the whole slot as sampled at that edge.
- R4: While eng_valid is 1 and eng_ready is 0, eng_valid, eng_cmd and cmd_idx stay unchanged.
- R5: At an edge where eng_valid and eng_ready are both 1, cmd_idx increases by one and eng_valid is 0 after that edge.
- R6: Accepting the command in slot DEPTH-1 returns cmd_idx to 0 and inverts the expected polarity, so a slot left from the previous lap is not taken again.
- R7: In a cycle with res_valid at 1, rsp_we is 1, rsp_idx gives the response slot, and rsp_slot equals res_data with bit 7 replaced by the response polarity. rsp_idx then advances by one.
- R8: The response polarity starts at 1 and inverts each time rsp_idx wraps from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_idx | output | IDX_W | Consumer index; selects the slot shown on cmd_slot |
| cmd_slot | input | SLOT_W | Contents of the command slot at cmd_idx |
| eng_valid | output | 1 | A captured command is offered to the engine |
| eng_ready | input | 1 | The engine takes the offered command |
| eng_cmd | output | SLOT_W | The captured command slot |
| res_valid | input | 1 | The engine presents a result to write |
| res_data | input | SLOT_W | Result payload; bit 7 is overwritten |
| rsp_we | output | 1 | Write strobe for the response ring |
| rsp_idx | output | IDX_W | Response slot being written |
| rsp_slot | output | SLOT_W | Response slot contents, including its valid bit |

## Verification
The ring is first left at its reset contents of all zeros, and then holds a slot with bit 7 clear. Neither should be taken while polarity 1 is expected, which shows that the valid bit is compared with a polarity and is not simply tested for being set. A single command held under a low ready shows that the offer holds still and the index stays put. A long run with an irregular ready pattern crosses the ring boundary twice. It is interrupted at the first wrap while slot 0 still holds the previous lap's command, which separates a correct polarity flip from a consumer that rereads stale slots. Ten responses cover both polarities of the response ring, including its wrap.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/cmdring_tracker.sv
// Slot index with a polarity bit that inverts on each wrap to slot 0.
module cmdring_tracker #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output logic             phase
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx   <= '0;
         phase <= 1'b1;
      end else if (step) begin
         if (idx == LAST) begin
            idx   <= '0;
            phase <= ~phase;
         end else begin
            idx <= idx + IDX_W'(1);
         end
      end
   end
endmodule

// File: rtl/cmdring_capture.sv
// Detects a fresh slot and holds it until the engine takes it.
module cmdring_capture #(
   parameter int SLOT_W   = 256,
   parameter int VBIT_POS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] slot,
   input  logic              exp_phase,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [SLOT_W-1:0] out_data,
   output logic              take
);
   logic              hold_q;
   logic [SLOT_W-1:0] data_q;
   logic              fresh;

   assign fresh     = !hold_q && (slot[VBIT_POS] == exp_phase);
   assign take      = hold_q && out_ready;
   assign out_valid = hold_q;
   assign out_data  = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         data_q <= '0;
      end else if (take) begin
         hold_q <= 1'b0;
      end else if (fresh) begin
         hold_q <= 1'b1;
         data_q <= slot;
      end
   end
endmodule

// File: rtl/vbit_cmd_consumer.sv
module vbit_cmd_consumer #(
   parameter int DEPTH      = 8,
   parameter int SLOT_BYTES = 32,
   parameter int VBIT_POS   = 7,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int SLOT_W = SLOT_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [IDX_W-1:0]  cmd_idx,
   input  logic [SLOT_W-1:0] cmd_slot,
   output logic              eng_valid,
   input  logic              eng_ready,
   output logic [SLOT_W-1:0] eng_cmd,
   input  logic              res_valid,
   input  logic [SLOT_W-1:0] res_data,
   output logic              rsp_we,
   output logic [IDX_W-1:0]  rsp_idx,
   output logic [SLOT_W-1:0] rsp_slot
);
   import cmdring_pkg::*;

   localparam logic [SLOT_W-1:0] VMASK = SLOT_W'(1) << VBIT_POS;

   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (VBIT_POS < 0 || VBIT_POS >= SLOT_W) begin : g_bad_vbit
      $error("VBIT_POS must lie inside the slot");
   end
   if (SLOT_BYTES % 4 != 0) begin : g_bad_slot
      $error("SLOT_BYTES must be a whole number of 32-bit words");
   end

   logic cmd_phase;
   logic rsp_phase;
   logic cmd_take;

   cmdring_capture #(.SLOT_W(SLOT_W), .VBIT_POS(VBIT_POS)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot      (cmd_slot),
      .exp_phase (cmd_phase),
      .out_ready (eng_ready),
      .out_valid (eng_valid),
      .out_data  (eng_cmd),
      .take      (cmd_take)
   );

   cmdring_tracker #(.DEPTH(DEPTH)) u_cmd_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (cmd_take),
      .idx   (cmd_idx),
      .phase (cmd_phase)
   );

   cmdring_tracker #(.DEPTH(DEPTH)) u_rsp_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (res_valid),
      .idx   (rsp_idx),
      .phase (rsp_phase)
   );

   assign rsp_we   = res_valid;
   assign rsp_slot = (res_data & ~VMASK) | (rsp_phase ? VMASK : '0);
endmodule

module vbit_cmd_consumer_chk #(
   parameter int DEPTH    = 8,
   parameter int SLOT_W   = 256,
   parameter int VBIT_POS = 7,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [IDX_W-1:0]  cmd_idx,
   input logic [SLOT_W-1:0] cmd_slot,
   input logic              eng_valid,
   input logic              eng_ready,
   input logic [SLOT_W-1:0] eng_cmd,
   input logic              rsp_we,
   input logic [IDX_W-1:0]  rsp_idx,
   input logic              cmd_phase,
   input logic              rsp_phase
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   assert_stale_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_valid && cmd_slot[VBIT_POS] != cmd_phase) |=> !eng_valid);

   assert_fresh_captured_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_valid && cmd_slot[VBIT_POS] == cmd_phase) |=>
         (eng_valid && eng_cmd == $past(cmd_slot)));

   assert_offer_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_valid && !eng_ready) |=> (eng_valid && $stable(eng_cmd) && $stable(cmd_idx)));

   assert_index_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_valid && eng_ready) |=> (!eng_valid && cmd_idx == $past(cmd_idx) + IDX_W'(1)));

   assert_cmd_wrap_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_valid && eng_ready && cmd_idx == LAST) |=> (cmd_phase != $past(cmd_phase)));

   assert_rsp_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_we |=> (rsp_idx == $past(rsp_idx) + IDX_W'(1)));

   assert_rsp_wrap_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_we && rsp_idx == LAST) |=> (rsp_phase != $past(rsp_phase)));
endmodule

bind vbit_cmd_consumer vbit_cmd_consumer_chk #(
   .DEPTH(DEPTH), .SLOT_W(SLOT_W), .VBIT_POS(VBIT_POS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_idx   (cmd_idx),
   .cmd_slot  (cmd_slot),
   .eng_valid (eng_valid),
   .eng_ready (eng_ready),
   .eng_cmd   (eng_cmd),
   .rsp_we    (rsp_we),
   .rsp_idx   (rsp_idx),
   .cmd_phase (cmd_phase),
   .rsp_phase (rsp_phase)
);

// File: tb/vbit_cmd_consumer_tb.sv
module vbit_cmd_consumer_tb;
   localparam int DEPTH  = 8;
   localparam int SLOT_W = 256;
   localparam int IDX_W  = 3;
   localparam int VB     = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [IDX_W-1:0]  cmd_idx;
   logic [SLOT_W-1:0] cmd_slot;
   logic              eng_valid;
   logic              eng_ready = 1'b0;
   logic [SLOT_W-1:0] eng_cmd;
   logic              res_valid = 1'b0;
   logic [SLOT_W-1:0] res_data = '0;
   logic              rsp_we;
   logic [IDX_W-1:0]  rsp_idx;
   logic [SLOT_W-1:0] rsp_slot;

   always #2.5 clk = ~clk;

   logic [SLOT_W-1:0] ring [DEPTH];
   assign cmd_slot = ring[cmd_idx];

   vbit_cmd_consumer #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_idx(cmd_idx), .cmd_slot(cmd_slot),
      .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_cmd(eng_cmd),
      .res_valid(res_valid), .res_data(res_data), .rsp_we(rsp_we),
      .rsp_idx(rsp_idx), .rsp_slot(rsp_slot)
   );

   int vectors = 0;
   int misses  = 0;
   int posted = 0, consumed = 0;
   int prod_idx = 0;
   bit prod_ph = 1'b1;
   int ridx = 0;
   bit rph = 1'b1;
   int rdy_mode = 0;
   int cyc = 0;
   logic [SLOT_W-1:0] cmdq[$];
   logic [SLOT_W-1:0] rspq[$];
   int                rspiq[$];

   task automatic check(input bit ok, input string req,
                        input logic [SLOT_W-1:0] act, input logic [SLOT_W-1:0] exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [SLOT_W-1:0] mk(input int n);
      logic [31:0] w;
      w = 32'(n) * 32'h9E37_79B1 + 32'h0BAD_F00D;
      return {8{w}};
   endfunction

   // ready pattern: 0 low, 1 high, 2 irregular
   always @(posedge clk) begin
      cyc++;
      #1;
      case (rdy_mode)
         0: eng_ready = 1'b0;
         1: eng_ready = 1'b1;
         default: eng_ready = (cyc % 3 != 1) && (cyc % 7 != 4);
      endcase
   end

   // producer: fills next slot, valid bit written with the producer's lap polarity
   task automatic post_cmd(input int n);
      logic [SLOT_W-1:0] s;
      while (posted - consumed >= DEPTH) @(posedge clk);
      @(posedge clk); #1;
      s = mk(n);
      s[VB] = prod_ph;
      ring[prod_idx] = s;
      cmdq.push_back(s);
      posted++;
      if (prod_idx == DEPTH - 1) begin prod_idx = 0; prod_ph = ~prod_ph; end
      else prod_idx++;
   endtask

   task automatic send_res(input int n);
      logic [SLOT_W-1:0] e;
      @(posedge clk); #1;
      res_data  = mk(n + 1000);
      res_valid = 1'b1;
      e = res_data;
      e[VB] = rph;
      rspq.push_back(e);
      rspiq.push_back(ridx);
      if (ridx == DEPTH - 1) begin ridx = 0; rph = ~rph; end
      else ridx++;
      @(posedge clk); #1;
      res_valid = 1'b0;
   endtask

   // monitor: commands taken by the engine and responses written
   always @(negedge clk) begin
      if (rst_n && eng_valid && eng_ready) begin
         if (cmdq.size() == 0) check(1'b0, "R3 unexpected command", eng_cmd, '0);
         else check(eng_cmd == cmdq[0], "R3 R5 command contents", eng_cmd, cmdq[0]);
         if (cmdq.size() != 0) void'(cmdq.pop_front());
         consumed++;
      end
      if (rst_n && res_valid) begin
         check(rsp_we == 1'b1, "R7 write strobe", SLOT_W'(rsp_we), SLOT_W'(1));
         if (rspq.size() != 0) begin
            check(rsp_idx == IDX_W'(rspiq[0]), "R7 response index",
                  SLOT_W'(rsp_idx), SLOT_W'(rspiq[0]));
            check(rsp_slot == rspq[0], "R7 R8 response slot", rsp_slot, rspq[0]);
            void'(rspq.pop_front());
            void'(rspiq.pop_front());
         end
      end else if (rst_n) begin
         if (rsp_we) check(1'b0, "R7 spurious write", SLOT_W'(rsp_we), '0);
      end
   end

   task automatic wait_consumed(input int n);
      while (consumed < n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) ring[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      @(negedge clk);
      check(cmd_idx == '0, "R1 cmd_idx", SLOT_W'(cmd_idx), '0);
      check(rsp_idx == '0, "R1 rsp_idx", SLOT_W'(rsp_idx), '0);
      check(eng_valid == 1'b0, "R1 eng_valid", SLOT_W'(eng_valid), '0);
      check(rsp_we == 1'b0, "R1 rsp_we", SLOT_W'(rsp_we), '0);

      // all-zero ring: polarity 1 expected, nothing taken
      repeat (4) @(negedge clk);
      check(eng_valid == 1'b0, "R1 R2 zero slot ignored", SLOT_W'(eng_valid), '0);

      // slot with payload but bit 7 clear
      begin
         logic [SLOT_W-1:0] s;
         s = mk(77);
         s[VB] = 1'b0;
         ring[0] = s;
      end
      repeat (5) @(negedge clk);
      check(eng_valid == 1'b0, "R2 stale polarity ignored", SLOT_W'(eng_valid), '0);
      check(cmd_idx == '0, "R2 index unmoved", SLOT_W'(cmd_idx), '0);

      // one command held with ready low
      post_cmd(1);
      repeat (6) @(negedge clk);
      check(eng_valid == 1'b1, "R3 R4 offer held", SLOT_W'(eng_valid), SLOT_W'(1));
      check(eng_cmd == cmdq[0], "R3 R4 held contents", eng_cmd, cmdq[0]);
      check(cmd_idx == '0, "R4 index held", SLOT_W'(cmd_idx), '0);
      rdy_mode = 1;
      wait_consumed(1);
      @(negedge clk);
      check(cmd_idx == IDX_W'(1), "R5 index advanced", SLOT_W'(cmd_idx), SLOT_W'(1));
      check(eng_valid == 1'b0, "R5 offer dropped", SLOT_W'(eng_valid), '0);

      // fill to the first wrap with irregular ready
      rdy_mode = 2;
      for (int i = 2; i <= 8; i++) post_cmd(i);
      wait_consumed(8);
      repeat (2) @(negedge clk);
      check(cmd_idx == '0, "R6 index wrapped", SLOT_W'(cmd_idx), '0);
      repeat (4) @(negedge clk);
      check(eng_valid == 1'b0, "R6 previous lap slot ignored", SLOT_W'(eng_valid), '0);
      check(consumed == 8, "R6 no reread", SLOT_W'(consumed), SLOT_W'(8));

      // second and third laps
      for (int i = 9; i <= 18; i++) post_cmd(i);
      wait_consumed(18);
      repeat (2) @(negedge clk);
      check(cmd_idx == IDX_W'(2), "R5 R6 index after 18", SLOT_W'(cmd_idx), SLOT_W'(2));
      check(cmdq.size() == 0, "R3 all commands delivered", SLOT_W'(cmdq.size()), '0);

      // responses across the response ring wrap
      for (int i = 0; i < 10; i++) begin
         send_res(i);
         if (i % 3 == 2) @(posedge clk);
      end
      repeat (3) @(negedge clk);
      check(rsp_idx == IDX_W'(2), "R8 response index after wrap", SLOT_W'(rsp_idx), SLOT_W'(2));
      check(rspq.size() == 0, "R7 all responses seen", SLOT_W'(rspq.size()), '0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule